// File: doc/BRIEF.md
# Memory Type Range Resolver

This block tells a memory pipeline which cacheability type applies to a 4 KiB page. It holds the range configuration: a bank of fixed-range type bytes that cover the first megabyte, a set of programmable base/mask range pairs, a control word with the fallback type and two enable bits, and an upper-memory boundary register. A lookup presents a page number and receives the resolved 8-bit type one clock later.

Configuration is written through a plain select/data write port, one 64-bit register per cycle. Lookups and writes can be issued in the same cycle. A lookup then sees the configuration that was in place before that write. Resolution follows a fixed order. First the global enable. Then the fixed bank, when it is switched on and the page lies below 1 MiB. Then the upper-memory write-back window. Then the programmable ranges, merged by a precedence rule. Last comes the fallback type.

Top module: `memtype_resolver`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high, and low otherwise; it is low while `rst_n` is low and after reset. `rsp_type` carries the result of that request.
- R2: When the global enable (control register bit 8) is 0, every lookup returns 0 (uncachable). This is the state after reset.
- R3: The fixed bank covers pages below 1 MiB in 88 entries. There are eight 64 KiB entries from address 0, sixteen 16 KiB entries from 0x80000 and sixty-four 4 KiB entries from 0xC0000, numbered upward in address order. Entry n is byte n%8 (bits 8*(n%8)+7 down to 8*(n%8)) of fixed register n/8, and fixed register k sits at select k (0 to 10).
- R4: When the fixed enable (control bit 9) is 1 and global enable is 1, a page below 1 MiB returns its fixed entry whatever the programmable ranges say. When fixed enable is 0, such a page resolves like any other page.
- R5: Programmable range i uses select 32+2i for its base register and 33+2i for its mask register. The base register holds the type in bits 7:0 and the base in bits PA_W-1:12. The mask register holds the mask in bits PA_W-1:12 and a valid bit at bit 11. A range hits when it is valid and (page AND mask) equals (base AND mask); a range whose valid bit is 0 never hits.
- R6: Several hitting ranges merge pairwise. If either type is 0 the result is 0. Write-back (6) with write-through (4) gives 4. Any other differing pair gives 0. Equal types keep their value.
- R7: A page not resolved by the fixed bank, the upper-memory window or any range returns the fallback type held in control bits 7:0 (select 16).
- R8: When the upper-memory register (select 17) is non-zero, pages from 4 GiB up to but not including its value return 6 (write-back). This holds even over ranges that hit. A zero value disables the window.
- R9: The upper-memory value keeps only bits PA_W-1:23 of the written data; lower bits are dropped.
- R10: A configuration write is seen by lookups issued in the following cycle and later. A lookup issued in the same cycle as a write resolves with the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (6) | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| lk_req | input | 1 | Lookup request strobe |
| lk_page | input | PA_W-12 (36) | Page number to resolve (byte address bits PA_W-1:12) |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_type | output | 8 | Resolved memory type |

## Verification
The bench probes the edges of each fixed granularity zone: the last 64 KiB page, the first 16 KiB page, the last 16 KiB page and the first and last 4 KiB pages. A design with a shifted index or a reversed byte order returns a neighbouring entry's byte. It programs overlaps that must merge to write-through, to uncachable through a differing pair, and to the shared type through an identical pair, and it places a range with a clear valid bit over a page. A wrong merge table or a missed valid check shows up as a wrong type. The upper-memory window is hit at 4 GiB and just below its truncated limit, and missed just above the truncated limit and just below 4 GiB. Missing truncation or an inclusive bound moves that edge. A write issued together with a lookup confirms that the lookup uses the old configuration, which a design that forwards write data would get wrong.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

  localparam logic [7:0] MT_UC = 8'd0;
  localparam logic [7:0] MT_WC = 8'd1;
  localparam logic [7:0] MT_WT = 8'd4;
  localparam logic [7:0] MT_WP = 8'd5;
  localparam logic [7:0] MT_WB = 8'd6;

  localparam int FIX_REGS    = 11;
  localparam int FIX_ENTRIES = FIX_REGS * 8;

  localparam int SEL_CTRL = 16;
  localparam int SEL_TOP2 = 17;
  localparam int SEL_VAR0 = 32;

  // Pairwise merge of two range types.
  function automatic logic [7:0] mt_combine(input logic [7:0] a, input logic [7:0] b);
    if (a == MT_UC || b == MT_UC) return MT_UC;
    if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) return MT_WT;
    if (a != b) return MT_UC;
    return a;
  endfunction

  // Map a page inside the first MiB (page bits 7:0) to its fixed entry number.
  function automatic logic [6:0] mt_fixed_index(input logic [7:0] pg);
    if (!pg[7])      return {4'b0000, pg[6:4]};          // 64 KiB zone: 0..7
    else if (!pg[6]) return 7'd8 + {3'b000, pg[5:2]};    // 16 KiB zone: 8..23
    else             return 7'd24 + {1'b0, pg[5:0]};     // 4 KiB zone: 24..87
  endfunction

endpackage

// File: rtl/mt_fixed_bank.sv
module mt_fixed_bank
  import memtype_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [7:0]  page_lo,
  output logic [7:0]  ent_type
);

  logic [7:0] ent_q [FIX_ENTRIES];
  logic [6:0] ent_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < FIX_ENTRIES; n++) ent_q[n] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < FIX_REGS; r++) begin
        if (wr_idx == r[3:0]) begin
          for (int b = 0; b < 8; b++) ent_q[r*8 + b] <= wr_data[8*b +: 8];
        end
      end
    end
  end

  assign ent_idx  = mt_fixed_index(page_lo);
  assign ent_type = ent_q[ent_idx];

endmodule

// File: rtl/mt_var_bank.sv
module mt_var_bank
  import memtype_pkg::*;
#(
  parameter int PA_W    = 48,
  parameter int NUM_VAR = 8,
  localparam int PFN_W  = PA_W - 12,
  localparam int VSEL_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VSEL_W-1:0]  wr_slot,
  input  logic               wr_is_mask,
  input  logic [63:0]        wr_data,
  input  logic [PFN_W-1:0]   page,
  output logic [NUM_VAR-1:0] hit_vec,
  output logic [NUM_VAR-1:0] uc_vec,
  output logic               any_hit,
  output logic [7:0]         res_type
);

  logic [NUM_VAR-1:0][7:0] slot_type;
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[63:PA_W], wr_data[10:8]};

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_slot
    logic [PFN_W-1:0] base_q, mask_q;
    logic [7:0]       type_q;
    logic             vld_q;
    logic             sel;

    assign sel = wr_en && (wr_slot == VSEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        type_q <= '0;
        vld_q  <= 1'b0;
      end else if (sel) begin
        if (wr_is_mask) begin
          mask_q <= wr_data[PA_W-1:12];
          vld_q  <= wr_data[11];
        end else begin
          base_q <= wr_data[PA_W-1:12];
          type_q <= wr_data[7:0];
        end
      end
    end

    assign hit_vec[i]   = vld_q && ((page & mask_q) == (base_q & mask_q));
    assign uc_vec[i]    = hit_vec[i] && (type_q == MT_UC);
    assign slot_type[i] = type_q;
  end

  always_comb begin
    logic       seen;
    logic [7:0] acc;
    seen = 1'b0;
    acc  = MT_UC;
    for (int i = 0; i < NUM_VAR; i++) begin
      if (hit_vec[i]) begin
        acc  = seen ? mt_combine(acc, slot_type[i]) : slot_type[i];
        seen = 1'b1;
      end
    end
    any_hit  = seen;
    res_type = acc;
  end

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int PA_W    = 48,
  parameter int NUM_VAR = 8,
  localparam int PFN_W  = PA_W - 12,
  localparam int VSEL_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1,
  localparam int SEL_W  = $clog2(SEL_VAR0 + 2 * NUM_VAR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [63:0]      cfg_wdata,
  input  logic             lk_req,
  input  logic [PFN_W-1:0] lk_page,
  output logic             rsp_valid,
  output logic [7:0]       rsp_type
);

  localparam logic [SEL_W-1:0] SEL_FIX_END = SEL_W'(FIX_REGS);
  localparam logic [SEL_W-1:0] SEL_CTRL_L  = SEL_W'(SEL_CTRL);
  localparam logic [SEL_W-1:0] SEL_TOP2_L  = SEL_W'(SEL_TOP2);
  localparam logic [SEL_W-1:0] SEL_VAR_LO  = SEL_W'(SEL_VAR0);
  localparam logic [SEL_W-1:0] SEL_VAR_HI  = SEL_W'(SEL_VAR0 + 2 * NUM_VAR);
  localparam logic [PFN_W-1:0] PFN_4G      = PFN_W'(1) << 20;
  localparam int               TOP2_W      = PA_W - 23;

  // configuration decode
  logic fix_we, ctrl_we, top2_we, var_we;
  assign fix_we  = cfg_we && (cfg_sel < SEL_FIX_END);
  assign ctrl_we = cfg_we && (cfg_sel == SEL_CTRL_L);
  assign top2_we = cfg_we && (cfg_sel == SEL_TOP2_L);
  assign var_we  = cfg_we && (cfg_sel >= SEL_VAR_LO) && (cfg_sel < SEL_VAR_HI);

  // control and upper-memory registers
  logic [7:0]        def_type_q;
  logic              glob_en_q, fix_en_q;
  logic [TOP2_W-1:0] top2_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_type_q <= MT_UC;
      glob_en_q  <= 1'b0;
      fix_en_q   <= 1'b0;
      top2_hi_q  <= '0;
    end else begin
      if (ctrl_we) begin
        def_type_q <= cfg_wdata[7:0];
        glob_en_q  <= cfg_wdata[8];
        fix_en_q   <= cfg_wdata[9];
      end
      if (top2_we) top2_hi_q <= cfg_wdata[PA_W-1:23];
    end
  end

  // fixed bank
  logic [7:0] fix_type_w;
  logic       low_mib_w, fix_sel_w;

  mt_fixed_bank u_fixed (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fix_we),
    .wr_idx   (cfg_sel[3:0]),
    .wr_data  (cfg_wdata),
    .page_lo  (lk_page[7:0]),
    .ent_type (fix_type_w)
  );

  assign low_mib_w = (lk_page[PFN_W-1:8] == '0);
  assign fix_sel_w = glob_en_q && fix_en_q && low_mib_w;

  // programmable ranges
  logic [NUM_VAR-1:0] var_hit_vec, var_uc_vec;
  logic               var_any_w, var_uc_w;
  logic [7:0]         var_type_w;

  mt_var_bank #(.PA_W(PA_W), .NUM_VAR(NUM_VAR)) u_var (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (var_we),
    .wr_slot    (cfg_sel[VSEL_W:1]),
    .wr_is_mask (cfg_sel[0]),
    .wr_data    (cfg_wdata),
    .page       (lk_page),
    .hit_vec    (var_hit_vec),
    .uc_vec     (var_uc_vec),
    .any_hit    (var_any_w),
    .res_type   (var_type_w)
  );

  assign var_uc_w = |var_uc_vec;

  // upper-memory write-back window
  logic [PFN_W-1:0] top2_lim_w;
  logic             tom2_hit_w;
  assign top2_lim_w = {top2_hi_q, 11'b0};
  assign tom2_hit_w = (|top2_hi_q) && (lk_page >= PFN_4G) && (lk_page < top2_lim_w);

  // resolution order
  logic [7:0] res_w;
  always_comb begin
    if (!glob_en_q)      res_w = MT_UC;
    else if (fix_sel_w)  res_w = fix_type_w;
    else if (tom2_hit_w) res_w = MT_WB;
    else if (var_any_w)  res_w = var_type_w;
    else                 res_w = def_type_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_type  <= MT_UC;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) rsp_type <= res_w;
    end
  end

  logic unused_hits;
  assign unused_hits = ^var_hit_vec;

endmodule

// File: rtl/mt_resolver_chk.sv
module mt_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_req,
  input logic       rsp_valid,
  input logic [7:0] rsp_type,
  input logic       glob_en_q,
  input logic       fix_sel_w,
  input logic [7:0] fix_type_w,
  input logic       tom2_hit_w,
  input logic       var_any_w,
  input logic       var_uc_w,
  input logic [7:0] var_type_w,
  input logic [7:0] def_type_q
);

  a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  a_r2_off_gives_uc: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !glob_en_q) |=> (rsp_type == 8'd0));

  a_r4_fixed_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && fix_sel_w) |=> (rsp_type == $past(fix_type_w)));

  a_r8_top2_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && glob_en_q && !fix_sel_w && tom2_hit_w) |=> (rsp_type == 8'd6));

  a_r7_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && glob_en_q && !fix_sel_w && !tom2_hit_w && !var_any_w)
      |=> (rsp_type == $past(def_type_q)));

  a_r6_uc_dominates: assert property (@(posedge clk) disable iff (!rst_n)
    var_uc_w |-> (var_any_w && var_type_w == 8'd0));

endmodule

bind memtype_resolver mt_resolver_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_req     (lk_req),
  .rsp_valid  (rsp_valid),
  .rsp_type   (rsp_type),
  .glob_en_q  (glob_en_q),
  .fix_sel_w  (fix_sel_w),
  .fix_type_w (fix_type_w),
  .tom2_hit_w (tom2_hit_w),
  .var_any_w  (var_any_w),
  .var_uc_w   (var_uc_w),
  .var_type_w (var_type_w),
  .def_type_q (def_type_q)
);

// File: tb/memtype_resolver_tb_top.sv
module memtype_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        lk_req = 1'b0;
  logic [35:0] lk_page = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_type;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memtype_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .lk_req(lk_req), .lk_page(lk_page), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
  );

  // shadow configuration
  logic [7:0]  fx [88];
  logic [63:0] vbase [8];
  logic [63:0] vmask [8];
  logic [63:0] ctrl_s = '0;
  logic [63:0] top2_s = '0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  function automatic logic [7:0] mix(input logic [7:0] a, input logic [7:0] b);
    if (a == b) return a;
    if ((a == 8'd6 && b == 8'd4) || (a == 8'd4 && b == 8'd6)) return 8'd4;
    return 8'd0;
  endfunction

  function automatic logic [7:0] model(input logic [35:0] pg);
    logic [63:0] addr, lim, m;
    logic [7:0]  t;
    int          e;
    bit          any;
    addr = {16'h0, pg, 12'h0};
    if (!ctrl_s[8]) return 8'd0;
    if (ctrl_s[9] && addr < 64'h100000) begin
      if (addr < 64'h80000)      e = int'(addr / 64'h10000);
      else if (addr < 64'hC0000) e = 8 + int'((addr - 64'h80000) / 64'h4000);
      else                       e = 24 + int'((addr - 64'hC0000) / 64'h1000);
      return fx[e];
    end
    lim = top2_s & 64'h0000_FFFF_FF80_0000;
    if (lim != 0 && addr >= 64'h1_0000_0000 && addr < lim) return 8'd6;
    any = 0;
    t = 8'd0;
    for (int i = 0; i < 8; i++) begin
      if (vmask[i][11]) begin
        m = vmask[i] & 64'h0000_FFFF_FFFF_F000;
        if ((addr & m) == (vbase[i] & m)) begin
          t = any ? mix(t, vbase[i][7:0]) : vbase[i][7:0];
          any = 1;
        end
      end
    end
    if (any) return t;
    return ctrl_s[7:0];
  endfunction

  function automatic void shadow_apply(input int sel, input logic [63:0] d);
    if (sel < 11) for (int b = 0; b < 8; b++) fx[sel*8 + b] = d[8*b +: 8];
    else if (sel == 16) ctrl_s = d;
    else if (sel == 17) top2_s = d;
    else if (sel >= 32 && sel < 48) begin
      if (((sel - 32) % 2) == 0) vbase[(sel - 32) / 2] = d;
      else                       vmask[(sel - 32) / 2] = d;
    end
  endfunction

  function automatic logic [63:0] mask_of(input logic [63:0] size);
    return ((~(size - 64'd1)) & 64'h0000_FFFF_FFFF_F000) | 64'h800;
  endfunction

  task automatic cfg_write(input int sel, input logic [63:0] d);
    @(negedge clk);
    lk_req = 1'b0; cfg_we = 1'b1; cfg_sel = sel[5:0]; cfg_wdata = d;
    shadow_apply(sel, d);
  endtask

  task automatic lookup(input logic [35:0] pg, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; lk_req = 1'b1; lk_page = pg;
    exp_q.push_back(model(pg)); tag_q.push_back(tag);
  endtask

  task automatic write_with_lookup(input int sel, input logic [63:0] d,
                                   input logic [35:0] pg, input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[5:0]; cfg_wdata = d; lk_req = 1'b1; lk_page = pg;
    exp_q.push_back(model(pg)); tag_q.push_back(tag);
    shadow_apply(sel, d);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cfg_we = 1'b0; lk_req = 1'b0;
    end
  endtask

  // monitor: responses come back in request order
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R1 unexpected valid: got valid=1 expected valid=0");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_type !== e) begin
          mismatched++;
          $display("FAIL %s: got %0h expected %0h", t, rsp_type, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    for (int n = 0; n < 88; n++) fx[n] = '0;
    for (int i = 0; i < 8; i++) begin vbase[i] = '0; vmask[i] = '0; end

    repeat (3) @(negedge clk);
    compared++;
    if (rsp_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset: got valid=%b expected valid=0", rsp_valid);
    end
    rst_n = 1'b1;
    idle(2);

    // R2: reset configuration has global enable clear
    lookup(36'h00010, "R2 disabled low page");
    lookup(36'h100000, "R2 disabled high page");
    idle(2);

    // R7 fallback, R4 fixed disabled falls through (R11-style control word at select 16)
    cfg_write(16, 64'h106);
    lookup(36'h00200, "R7 fallback WB");
    lookup(36'h00010, "R4 fixed off falls to fallback");

    // R3 fill fixed registers with distinct bytes
    for (int r = 0; r < 11; r++) begin
      d = '0;
      for (int b = 0; b < 8; b++) d[8*b +: 8] = 8'h20 + 8'(r*8 + b);
      cfg_write(r, d);
    end
    // R10: lookup in the write cycle sees old control (fixed still off)
    write_with_lookup(16, 64'h306, 36'h00000, "R10 same-cycle write old config");
    lookup(36'h00000, "R10 next-cycle sees fixed enable");
    lookup(36'h00035, "R3 64K entry 3");
    lookup(36'h0007F, "R3 last 64K page");
    lookup(36'h00080, "R3 first 16K page");
    lookup(36'h0009C, "R3 16K entry 15");
    lookup(36'h000BF, "R3 last 16K page");
    lookup(36'h000C0, "R3 first 4K page");
    lookup(36'h000FF, "R3 last 4K page");
    idle(1);

    // R5 range 0: WT over 0..2 MiB
    cfg_write(32, 64'h0 | 64'h4);
    cfg_write(33, mask_of(64'h200000));
    lookup(36'h00010, "R4 fixed overrides range");
    lookup(36'h00180, "R5 range hit WT");
    // R6 range 1 WB over 1..2 MiB -> WT; range 2 UC at 0x1C0000 256K
    cfg_write(34, 64'h100000 | 64'h6);
    cfg_write(35, mask_of(64'h100000));
    cfg_write(36, 64'h1C0000 | 64'h0);
    cfg_write(37, mask_of(64'h40000));
    lookup(36'h00150, "R6 WB+WT gives WT");
    lookup(36'h001C0, "R6 UC dominates");
    lookup(36'h001BF, "R6 below UC range");
    // differing WC + WP -> UC
    cfg_write(38, 64'h4000_0000 | 64'h1);
    cfg_write(39, mask_of(64'h100000));
    cfg_write(40, 64'h4000_0000 | 64'h5);
    cfg_write(41, mask_of(64'h200000));
    lookup(36'h40000, "R6 WC+WP gives UC");
    lookup(36'h40100, "R5 single WP hit");
    // identical WB + WB
    cfg_write(42, 64'h8000_0000 | 64'h6);
    cfg_write(43, mask_of(64'h1000));
    cfg_write(44, 64'h8000_0000 | 64'h6);
    cfg_write(45, mask_of(64'h2000));
    lookup(36'h80000, "R6 identical WB");
    lookup(36'h80001, "R5 wider range only");
    // range 7 with valid clear: ignored
    cfg_write(46, 64'h2000_0000 | 64'h0);
    cfg_write(47, mask_of(64'h100000) & ~64'h800);
    lookup(36'h20000, "R5 invalid range ignored");
    lookup(36'h300000, "R7 no hit far page");
    idle(2);

    // R8: range 7 valid UC at 4 GiB, upper window still zero
    cfg_write(47, mask_of(64'h100_0000));
    cfg_write(46, 64'h1_0000_0000 | 64'h0);
    cfg_write(16, 64'h301);
    lookup(36'h100000, "R8 zero window disabled");
    cfg_write(17, 64'h1_4000_0000 | 64'h7F_F123);
    lookup(36'h100000, "R8 window at 4GiB overrides UC");
    lookup(36'h13FFFF, "R8 last page in window");
    lookup(36'h140000, "R9 truncated limit excluded");
    lookup(36'h1407FE, "R9 dropped low bits not in window");
    lookup(36'h0FFFFF, "R8 below 4GiB not in window");
    idle(1);

    // R4 fixed disable again
    cfg_write(16, 64'h101);
    lookup(36'h00010, "R4 fixed off uses range WT");
    // R2 global disable with everything programmed
    cfg_write(16, 64'h201);
    lookup(36'h100000, "R2 disabled window page");
    lookup(36'h00010, "R2 disabled fixed page");
    idle(4);

    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R1 missing responses: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule